// File: doc/BRIEF.md
# Keyed Write-Protect Lock

This block guards the write path of a small register bank. It holds one 16-bit protection word made of a 14-bit key and a lock bit. From that word and an external protect pin, it produces a write-permit signal. The other configuration registers in the bank use this signal to decide whether a write strobe may update them. The protection word can be read at any time through the same read request that serves the rest of the bank.

Writes to the protection word follow their own rules. While the lock is clear, a write stores a new key and a new lock bit together, so a key can be chosen in the same write that engages the lock. While the lock is set, the only write that takes effect is one that clears the lock bit and carries a key equal to the stored key. That write unlocks the bank and leaves the key unchanged. A second way to block writes is an active-low pin, once software has assigned it to write protection. While that pin is asserted, every write is refused and reads report the lock bit as set.

Top module: `wpl_top`

## Requirements
- R1: After reset the protection word reads 0xAAA8 (key 0x2AAA, lock 0) and write permit is high.
- R2: With the lock clear and no pin block, a write to command 0x00 stores bits [15:2] as the key and bit [0] as the lock. Bit [1] is discarded and always reads 0.
- R3: Write permit is combinational and applies in the same cycle. It is low whenever the stored lock is 1 and high when the lock is 0 with no pin block.
- R4: While locked, a write to command 0x00 with bit [0] = 0 and bits [15:2] equal to the stored key clears the lock and keeps the stored key.
- R5: While locked, a write to command 0x00 with bit [0] = 0 and a key that differs from the stored key changes nothing.
- R6: While locked, a write to command 0x00 with bit [0] = 1 changes nothing, even if its key field matches.
- R7: While unlocked, a single write may load a new key and set the lock. Only that new key unlocks afterwards.
- R8: When the pin is enabled for protection (enable = 1) and driven low, all writes are ignored, write permit is low, and read-back shows bit [0] as 1. The stored lock is not altered.
- R9: When the pin enable is 0, or the pin is high, the pin has no effect on permit, writes or read-back.
- R10: Read-back is allowed in every lock state. rd_data carries the word while rd_req is 1 and is 0 while rd_req is 0.
- R11: Strobes to other command codes, and a command-0x00 value presented with wr_en low, leave the protection word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bank |
| wr_cmd | input | 8 | Command code of the write |
| wr_data | input | 16 | Write data |
| rd_req | input | 1 | Read request for the protection word |
| pin_wp_n | input | 1 | External protect pin, active low |
| pin_wp_en | input | 1 | Assigns the pin to write protection when 1 |
| wr_permit | output | 1 | High when bank writes may take effect |
| rd_data | output | 16 | Protection word read-back |

## Verification
The hardest case to reach is a locked word receiving a write that clears the lock bit. Whether that write is accepted depends only on a key the bench itself loaded earlier. The stimulus table therefore first loads a chosen key and sets the lock in one write. It then tries a wrong key, a correct key with the lock bit still set, and finally the correct key with the lock bit clear, checking the read-back after each. The pin block is then layered over an unlocked word: the read-back shows a forced lock while the stored bit stays clear, which becomes visible once the pin is released.

// File: rtl/wpl_pkg.sv
package wpl_pkg;
  localparam int KEY_W  = 14;
  localparam int WORD_W = KEY_W + 2;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic             lock;
  } wpl_state_t;

  // Key field of an incoming data word (bits above the reserved bit).
  function automatic logic [KEY_W-1:0] key_field(input logic [WORD_W-1:0] d);
    return d[WORD_W-1:2];
  endfunction

  // Lock field of an incoming data word.
  function automatic logic lock_field(input logic [WORD_W-1:0] d);
    return d[0];
  endfunction

  // Read-back word; the reserved bit is always zero, the pin may force the lock.
  function automatic logic [WORD_W-1:0] word_of(input wpl_state_t s, input logic force_lock);
    return {s.key, 1'b0, s.lock | force_lock};
  endfunction
endpackage

// File: rtl/wpl_gate.sv
module wpl_gate (
  input  logic stored_lock,
  input  logic pin_wp_n,
  input  logic pin_wp_en,
  output logic pin_block,
  output logic wr_permit
);
  always_comb begin
    pin_block = pin_wp_en & ~pin_wp_n;
    wr_permit = ~stored_lock & ~pin_block;
  end
endmodule

// File: rtl/wpl_decide.sv
module wpl_decide
  import wpl_pkg::*;
#(
  parameter int               CMD_W  = 8,
  parameter logic [CMD_W-1:0] WP_CMD = '0
) (
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_cmd,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pin_block,
  input  wpl_state_t        cur,
  output logic              load,
  output wpl_state_t        nxt,
  output logic              ev_unlock,
  output logic              ev_key_miss,
  output logic              ev_relock_skip
);
  logic             own_hit;
  logic [KEY_W-1:0] key_in;
  logic             lock_in;
  logic             key_same;
  logic             rsvd_unused;

  assign rsvd_unused = wr_data[1];

  always_comb begin
    own_hit        = wr_en && (wr_cmd == WP_CMD) && !pin_block;
    key_in         = key_field(wr_data);
    lock_in        = lock_field(wr_data);
    key_same       = (key_in == cur.key);
    load           = 1'b0;
    nxt            = cur;
    ev_unlock      = 1'b0;
    ev_key_miss    = 1'b0;
    ev_relock_skip = 1'b0;
    if (own_hit) begin
      if (!cur.lock) begin
        load     = 1'b1;
        nxt.key  = key_in;
        nxt.lock = lock_in;
      end else if (lock_in) begin
        ev_relock_skip = 1'b1;
      end else if (key_same) begin
        load      = 1'b1;
        nxt.lock  = 1'b0;
        ev_unlock = 1'b1;
      end else begin
        ev_key_miss = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpl_store.sv
module wpl_store
  import wpl_pkg::*;
#(
  parameter logic [KEY_W-1:0] RST_KEY  = 14'h2AAA,
  parameter logic             RST_LOCK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  wpl_state_t nxt,
  input  logic       pin_block,
  input  logic       ev_unlock,
  input  logic       ev_key_miss,
  input  logic       ev_relock_skip,
  output wpl_state_t st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.key  <= RST_KEY;
      st_q.lock <= RST_LOCK;
    end else if (load) begin
      st_q <= nxt;
    end
  end

  // R4
  unlock_keeps_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unlock |=> (!st_q.lock && st_q.key == $past(st_q.key)));

  // R5
  key_miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_key_miss |=> $stable(st_q));

  // R6
  relock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_relock_skip |=> $stable(st_q));

  // R8
  pin_block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_block |=> $stable(st_q));
endmodule

// File: rtl/wpl_top.sv
module wpl_top
  import wpl_pkg::*;
#(
  parameter int               CMD_W    = 8,
  parameter logic [CMD_W-1:0] WP_CMD   = '0,
  parameter logic [KEY_W-1:0] RST_KEY  = 14'h2AAA,
  parameter logic             RST_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_cmd,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              pin_wp_n,
  input  logic              pin_wp_en,
  output logic              wr_permit,
  output logic [WORD_W-1:0] rd_data
);
  wpl_state_t st_q;
  wpl_state_t nxt;
  logic       pin_block;
  logic       load;
  logic       ev_unlock;
  logic       ev_key_miss;
  logic       ev_relock_skip;

  wpl_gate gate_i (
    .stored_lock (st_q.lock),
    .pin_wp_n    (pin_wp_n),
    .pin_wp_en   (pin_wp_en),
    .pin_block   (pin_block),
    .wr_permit   (wr_permit)
  );

  wpl_decide #(.CMD_W(CMD_W), .WP_CMD(WP_CMD)) decide_i (
    .wr_en          (wr_en),
    .wr_cmd         (wr_cmd),
    .wr_data        (wr_data),
    .pin_block      (pin_block),
    .cur            (st_q),
    .load           (load),
    .nxt            (nxt),
    .ev_unlock      (ev_unlock),
    .ev_key_miss    (ev_key_miss),
    .ev_relock_skip (ev_relock_skip)
  );

  wpl_store #(.RST_KEY(RST_KEY), .RST_LOCK(RST_LOCK)) store_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (load),
    .nxt            (nxt),
    .pin_block      (pin_block),
    .ev_unlock      (ev_unlock),
    .ev_key_miss    (ev_key_miss),
    .ev_relock_skip (ev_relock_skip),
    .st_q           (st_q)
  );

  assign rd_data = rd_req ? word_of(st_q, pin_block) : '0;

  // R2
  open_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit && wr_en && wr_cmd == WP_CMD)
      |=> (st_q.key == $past(key_field(wr_data)) && st_q.lock == $past(lock_field(wr_data))));

  // R3
  locked_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q.lock) && !$past(load)) |-> !wr_permit);

  // R11
  foreign_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_cmd != WP_CMD) |=> $stable(st_q));
endmodule

// File: tb/wpl_top_tb_top.sv
module wpl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_cmd = '0;
  logic [15:0] wr_data = '0;
  logic        rd_req = 1'b1;
  logic        pin_wp_n = 1'b1;
  logic        pin_wp_en = 1'b0;
  logic        wr_permit;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wpl_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .rd_req(rd_req), .pin_wp_n(pin_wp_n), .pin_wp_en(pin_wp_en),
    .wr_permit(wr_permit), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  cmd;
    logic [15:0] data;
    logic        pen;
    logic        pn;
    logic        permit;
    logic [15:0] rd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h05, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'hAAA8, 8'd11}, // R11 other code
    '{1'b1, 8'h00, 16'h1236, 1'b0, 1'b1, 1'b1, 16'h1234, 8'd2},  // R2 bit1 dropped
    '{1'b1, 8'h00, 16'h5679, 1'b0, 1'b1, 1'b1, 16'h5679, 8'd7},  // R7 key + lock
    '{1'b1, 8'h04, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h5679, 8'd3},  // R3 permit low
    '{1'b1, 8'h00, 16'h1234, 1'b0, 1'b1, 1'b0, 16'h5679, 8'd5},  // R5 wrong key
    '{1'b1, 8'h00, 16'h567B, 1'b0, 1'b1, 1'b0, 16'h5679, 8'd6},  // R6 lock bit kept
    '{1'b0, 8'h00, 16'h5678, 1'b0, 1'b1, 1'b0, 16'h5679, 8'd11}, // R11 no strobe
    '{1'b1, 8'h00, 16'h5678, 1'b0, 1'b1, 1'b0, 16'h5678, 8'd4},  // R4 unlock
    '{1'b0, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h5678, 8'd3},  // R3 permit high
    '{1'b1, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h5679, 8'd8},  // R8 pin blocks
    '{1'b1, 8'h06, 16'h1111, 1'b1, 1'b0, 1'b0, 16'h5679, 8'd8},  // R8 pin blocks
    '{1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h5678, 8'd9},  // R9 pin unassigned
    '{1'b1, 8'h00, 16'hFFFC, 1'b1, 1'b1, 1'b1, 16'hFFFC, 8'd9},  // R9 pin high
    '{1'b1, 8'h00, 16'h0001, 1'b0, 1'b1, 1'b1, 16'h0001, 8'd7},  // R7 zero key
    '{1'b1, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 8'd4}   // R4 unlock
  };

  task automatic check(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("reset readback", 1, rd_data, 16'hAAA8);         // R1
    check("reset permit", 1, {15'd0, wr_permit}, 16'd1);  // R1

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en     = VECS[i].wr;
      wr_cmd    = VECS[i].cmd;
      wr_data   = VECS[i].data;
      pin_wp_en = VECS[i].pen;
      pin_wp_n  = VECS[i].pn;
      #1;
      check("permit", int'(VECS[i].req), {15'd0, wr_permit}, {15'd0, VECS[i].permit});
      @(posedge clk);
      #1;
      check("readback", int'(VECS[i].req), rd_data, VECS[i].rd);
    end

    // R10: lock with key 1, then read with and without request
    @(negedge clk);
    pin_wp_en = 1'b0; pin_wp_n = 1'b1;
    wr_en = 1'b1; wr_cmd = 8'h00; wr_data = 16'h0005;
    @(negedge clk);
    wr_en = 1'b0;
    rd_req = 1'b0;
    #1;
    check("no request reads zero", 10, rd_data, 16'h0000);  // R10
    rd_req = 1'b1;
    #1;
    check("read while locked", 10, rd_data, 16'h0005);      // R10

    // R1: reset while locked restores the default word
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("mid-run reset readback", 1, rd_data, 16'hAAA8);  // R1
    check("mid-run reset permit", 1, {15'd0, wr_permit}, 16'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule